// File: doc/BRIEF.md
# Multi-Plane Frame Buffer Address Generator

This block supplies the write address for each 32-bit word that a pixel packer sends to memory. A frame can occupy one, two or three memory planes, such as luma plus interleaved chroma, or luma plus two separate chroma planes. Each plane has two base addresses, one in set A and one in set B, and a line pitch. At each frame start the block picks one base set for all planes. It then moves each plane's address forward word by word within a line and by the pitch from line to line.

Three optional features can be configured. Ping-pong operation switches between the two base sets on successive frames. Line-ring wrapping sends every plane back to its base after a power-of-two number of lines, so software can use a buffer only a few lines deep. A divided line event gives software a one-cycle pulse every 2^N completed lines.

The word strobes carry no data and the block accepts them in every cycle, so there is no back-pressure. The strobes, line end and frame start are plain one-cycle pulses.

Top module: `plane_addr_gen`

## Requirements
- R1: While reset is held and afterwards, until the first frame start, every plane address reads 0, `buf_idx` reads 0 and `line_evt` reads 0.
- R2: A frame start loads every plane address with that plane's base from the chosen set (`buf_idx` 0 = set A, 1 = set B). The result is visible on the next cycle. With ping-pong off, every frame uses set A.
- R3: With ping-pong on, successive frames use set A, set B, set A, and so on. The first frame after ping-pong is switched on uses set A. `buf_idx` changes only on a frame start.
- R4: A word strobe on an active plane adds 4 to that plane's address on the next cycle. An inactive plane ignores word strobes and line ends and keeps its loaded base address.
- R5: A line end moves the luma plane (plane 0) to its previous line start plus its pitch. A word strobe in the same cycle as a line end is not counted. A frame start takes priority over both.
- R6: `cfg_mode` selects the plane layout:
  - 0: one plane.
  - 1: two planes, and the chroma plane advances on every line.
  - 2: two planes, 4:2:0.
  - 3: three planes, 4:2:0.

  In the 4:2:0 layouts, the chroma planes advance by their pitch only on the line end that completes the 2nd, 4th, 6th, ... line since frame start. On the other line ends they return to their current line start.
- R7: With wrapping on and code M, the line end that completes a multiple of 2^M lines since frame start returns every active plane to its base address.
- R8: With wrapping off, the addresses keep advancing for the whole frame. For example, after 130 lines with pitch 0x100 the luma address is base + 0x8200.
- R9: With event code N, `line_evt` is high for exactly one cycle. That cycle is the one after each line end that completes a multiple of 2^N lines counted from frame start.
- R10: The mode, ping-pong enable, wrap settings, event code, bases and pitches are all captured at frame start. Changing them during a frame has no effect until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that begins a frame |
| line_end | input | 1 | One-cycle pulse that ends a line |
| word_vld | input | 3 | Per-plane word-written strobes |
| cfg_mode | input | 2 | Plane layout code (R6) |
| cfg_pingpong | input | 1 | Alternate base sets per frame |
| cfg_wrap_en | input | 1 | Enable line-ring wrapping |
| cfg_wrap_code | input | 3 | Wrap after 2^code lines |
| cfg_evt_code | input | 3 | Event after every 2^code lines |
| cfg_base_a | input | 96 | Set A bases, plane p at bits [32p+31:32p] |
| cfg_base_b | input | 96 | Set B bases, same layout |
| cfg_pitch | input | 48 | Pitches, plane p at bits [16p+15:16p] |
| plane_addr | output | 96 | Current word address per plane |
| buf_idx | output | 1 | Base set in use (0 = A, 1 = B) |
| line_evt | output | 1 | Line-interval event pulse |

## Verification
The hardest situation to reach is the line end where the 4:2:0 chroma step and the line-ring wrap meet. At that point the chroma planes must return to base, not advance. The stimulus uses a four-line ring with a two-line event interval, so one vector walk covers lines that advance chroma, lines that hold it, and the wrap. The widest event divider needs 128 line ends before its single pulse. A directed loop drives those lines with wrapping off and then checks the accumulated luma address.

// File: rtl/pag_pkg.sv
package pag_pkg;
  localparam int unsigned NPLANES    = 3;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned CODEW      = 3;

  typedef enum logic [1:0] {
    PM_ONE        = 2'd0,
    PM_TWO_FULL   = 2'd1,
    PM_TWO_HALF   = 2'd2,
    PM_THREE_HALF = 2'd3
  } plane_mode_e;

  function automatic logic [NPLANES-1:0] active_planes(plane_mode_e m);
    case (m)
      PM_ONE:                    return 3'b001;
      PM_TWO_FULL, PM_TWO_HALF:  return 3'b011;
      default:                   return 3'b111;
    endcase
  endfunction

  function automatic logic half_chroma(plane_mode_e m);
    return (m == PM_TWO_HALF) || (m == PM_THREE_HALF);
  endfunction
endpackage

// File: rtl/pag_frame_ctl.sv
module pag_frame_ctl
  import pag_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 line_end,
  input  logic [1:0]           cfg_mode,
  input  logic                 cfg_pingpong,
  input  logic                 cfg_wrap_en,
  input  logic [CODEW-1:0]     cfg_wrap_code,
  input  logic [CODEW-1:0]     cfg_evt_code,
  output logic                 sel_load,
  output logic                 buf_idx,
  output logic [NPLANES-1:0]   act_mask,
  output logic                 wrap_now,
  output logic                 chroma_step,
  output logic                 line_evt
);
  logic             next_sel_q;
  logic             half_q, wrap_en_q;
  logic [CODEW-1:0] wrap_code_q, evt_code_q;
  logic [CW-1:0]    lcnt_q, lnext, wrap_mask, evt_mask;
  logic             lend_eff;

  assign sel_load    = cfg_pingpong ? next_sel_q : 1'b0;
  assign lnext       = lcnt_q + CW'(1);
  assign wrap_mask   = (CW'(1) << wrap_code_q) - CW'(1);
  assign evt_mask    = (CW'(1) << evt_code_q) - CW'(1);
  assign lend_eff    = line_end && !frame_start;
  assign wrap_now    = lend_eff && wrap_en_q && ((lnext & wrap_mask) == '0);
  assign chroma_step = !half_q || lcnt_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_sel_q  <= 1'b0;
      buf_idx     <= 1'b0;
      act_mask    <= '0;
      half_q      <= 1'b0;
      wrap_en_q   <= 1'b0;
      wrap_code_q <= '0;
      evt_code_q  <= '0;
      lcnt_q      <= '0;
      line_evt    <= 1'b0;
    end else begin
      line_evt <= lend_eff && ((lnext & evt_mask) == '0);
      if (frame_start) begin
        buf_idx     <= sel_load;
        next_sel_q  <= cfg_pingpong ? ~next_sel_q : 1'b0;
        act_mask    <= active_planes(plane_mode_e'(cfg_mode));
        half_q      <= half_chroma(plane_mode_e'(cfg_mode));
        wrap_en_q   <= cfg_wrap_en;
        wrap_code_q <= cfg_wrap_code;
        evt_code_q  <= cfg_evt_code;
        lcnt_q      <= '0;
      end else if (line_end) begin
        lcnt_q <= lnext;
      end
    end
  end

  // R9
  evt_follows_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_evt |-> $past(line_end));

  // R3
  buf_change_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_idx != $past(buf_idx)) |-> $past(frame_start));

  // R2
  single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !cfg_pingpong) |=> (buf_idx == 1'b0));
endmodule

// File: rtl/pag_plane_addr.sv
module pag_plane_addr
  import pag_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_base,
  input  logic [PW-1:0] load_pitch,
  input  logic          active,
  input  logic          word_vld,
  input  logic          line_end,
  input  logic          wrap_now,
  input  logic          step,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] base_q, lstart_q, next_start;
  logic [PW-1:0] pitch_q;

  assign next_start = lstart_q + AW'(pitch_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      pitch_q  <= '0;
      lstart_q <= '0;
      addr     <= '0;
    end else if (load) begin
      base_q   <= load_base;
      pitch_q  <= load_pitch;
      lstart_q <= load_base;
      addr     <= load_base;
    end else if (active && line_end) begin
      if (wrap_now) begin
        lstart_q <= base_q;
        addr     <= base_q;
      end else if (step) begin
        lstart_q <= next_start;
        addr     <= next_start;
      end else begin
        addr <= lstart_q;
      end
    end else if (active && word_vld) begin
      addr <= addr + AW'(WORD_BYTES);
    end
  end

  // R4
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && word_vld && !line_end && !load) |=> (addr == $past(addr) + AW'(WORD_BYTES)));

  // R4
  idle_plane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load) |=> $stable(addr));

  // R7
  wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && line_end && wrap_now && !load) |=> (addr == base_q));
endmodule

// File: rtl/plane_addr_gen.sv
module plane_addr_gen
  import pag_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned PW = 16,
  parameter int unsigned CW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic                  line_end,
  input  logic [NPLANES-1:0]    word_vld,
  input  logic [1:0]            cfg_mode,
  input  logic                  cfg_pingpong,
  input  logic                  cfg_wrap_en,
  input  logic [CODEW-1:0]      cfg_wrap_code,
  input  logic [CODEW-1:0]      cfg_evt_code,
  input  logic [NPLANES*AW-1:0] cfg_base_a,
  input  logic [NPLANES*AW-1:0] cfg_base_b,
  input  logic [NPLANES*PW-1:0] cfg_pitch,
  output logic [NPLANES*AW-1:0] plane_addr,
  output logic                  buf_idx,
  output logic                  line_evt
);
  logic               sel_load, wrap_now, chroma_step;
  logic [NPLANES-1:0] act_mask;

  pag_frame_ctl #(.CW(CW)) ctl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .line_end      (line_end),
    .cfg_mode      (cfg_mode),
    .cfg_pingpong  (cfg_pingpong),
    .cfg_wrap_en   (cfg_wrap_en),
    .cfg_wrap_code (cfg_wrap_code),
    .cfg_evt_code  (cfg_evt_code),
    .sel_load      (sel_load),
    .buf_idx       (buf_idx),
    .act_mask      (act_mask),
    .wrap_now      (wrap_now),
    .chroma_step   (chroma_step),
    .line_evt      (line_evt)
  );

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    logic [AW-1:0] base_sel;
    logic          step;
    assign base_sel = sel_load ? cfg_base_b[p*AW +: AW] : cfg_base_a[p*AW +: AW];
    if (p == 0) begin : g_luma
      assign step = 1'b1;
    end else begin : g_chroma
      assign step = chroma_step;
    end
    pag_plane_addr #(.AW(AW), .PW(PW)) unit_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (frame_start),
      .load_base  (base_sel),
      .load_pitch (cfg_pitch[p*PW +: PW]),
      .active     (act_mask[p]),
      .word_vld   (word_vld[p]),
      .line_end   (line_end),
      .wrap_now   (wrap_now),
      .step       (step),
      .addr       (plane_addr[p*AW +: AW])
    );
  end
endmodule

// File: tb/plane_addr_gen_tb.sv
module plane_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0, line_end = 1'b0;
  logic [2:0]  word_vld = '0;
  logic [1:0]  cfg_mode = 2'd3;
  logic        cfg_pingpong = 1'b1, cfg_wrap_en = 1'b1;
  logic [2:0]  cfg_wrap_code = 3'd2, cfg_evt_code = 3'd1;
  logic [95:0] cfg_base_a = {32'h3000, 32'h2000, 32'h1000};
  logic [95:0] cfg_base_b = {32'hA000, 32'h9000, 32'h8000};
  logic [47:0] cfg_pitch  = {16'h0080, 16'h0080, 16'h0100};
  logic [95:0] plane_addr;
  logic        buf_idx, line_evt;
  int          n_chk = 0, n_fail = 0, evt_seen;

  always #10 clk = ~clk;

  plane_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_end(line_end),
    .word_vld(word_vld), .cfg_mode(cfg_mode), .cfg_pingpong(cfg_pingpong),
    .cfg_wrap_en(cfg_wrap_en), .cfg_wrap_code(cfg_wrap_code),
    .cfg_evt_code(cfg_evt_code), .cfg_base_a(cfg_base_a), .cfg_base_b(cfg_base_b),
    .cfg_pitch(cfg_pitch), .plane_addr(plane_addr), .buf_idx(buf_idx),
    .line_evt(line_evt)
  );

  typedef struct packed {
    logic        fs;
    logic        le;
    logic [2:0]  vld;
    logic [31:0] a0, a1, a2;
    logic        bi;
    logic        ev;
  } vec_t;

  // Three planes 4:2:0, ping-pong on, wrap every 4 lines (R7), event every 2 lines (R9)
  localparam vec_t VECS [14] = '{
    '{1'b1, 1'b0, 3'b000, 32'h1000, 32'h2000, 32'h3000, 1'b0, 1'b0}, // R2 set A
    '{1'b0, 1'b0, 3'b111, 32'h1004, 32'h2004, 32'h3004, 1'b0, 1'b0}, // R4
    '{1'b0, 1'b0, 3'b001, 32'h1008, 32'h2004, 32'h3004, 1'b0, 1'b0}, // R4
    '{1'b0, 1'b1, 3'b000, 32'h1100, 32'h2000, 32'h3000, 1'b0, 1'b0}, // R5 R6 hold chroma
    '{1'b0, 1'b0, 3'b011, 32'h1104, 32'h2004, 32'h3000, 1'b0, 1'b0}, // R4
    '{1'b0, 1'b1, 3'b000, 32'h1200, 32'h2080, 32'h3080, 1'b0, 1'b1}, // R6 step, R9
    '{1'b0, 1'b0, 3'b111, 32'h1204, 32'h2084, 32'h3084, 1'b0, 1'b0}, // R4
    '{1'b0, 1'b1, 3'b000, 32'h1300, 32'h2080, 32'h3080, 1'b0, 1'b0}, // R6
    '{1'b0, 1'b1, 3'b000, 32'h1000, 32'h2000, 32'h3000, 1'b0, 1'b1}, // R7 wrap, R9
    '{1'b0, 1'b0, 3'b100, 32'h1000, 32'h2000, 32'h3004, 1'b0, 1'b0}, // R4
    '{1'b1, 1'b0, 3'b000, 32'h8000, 32'h9000, 32'hA000, 1'b1, 1'b0}, // R3 set B
    '{1'b0, 1'b1, 3'b111, 32'h8100, 32'h9000, 32'hA000, 1'b1, 1'b0}, // R5 strobe dropped
    '{1'b1, 1'b0, 3'b000, 32'h1000, 32'h2000, 32'h3000, 1'b0, 1'b0}, // R3 back to A
    '{1'b0, 1'b0, 3'b000, 32'h1000, 32'h2000, 32'h3000, 1'b0, 1'b0}  // R4 hold
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs settled
  task automatic apply(input logic fs, input logic le, input logic [2:0] vld);
    frame_start = fs; line_end = le; word_vld = vld;
    @(negedge clk);
    frame_start = 1'b0; line_end = 1'b0; word_vld = '0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 addr0", plane_addr[31:0], 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 addr1", plane_addr[63:32], 32'h0);
    chk("R1 addr2", plane_addr[95:64], 32'h0);
    chk("R1 buf", {31'd0, buf_idx}, 32'd0);
    chk("R1 evt", {31'd0, line_evt}, 32'd0);

    for (int i = 0; i < 14; i++) begin
      apply(VECS[i].fs, VECS[i].le, VECS[i].vld);
      chk($sformatf("R2-7 vec%0d a0", i), plane_addr[31:0],  VECS[i].a0);
      chk($sformatf("R6 vec%0d a1", i),   plane_addr[63:32], VECS[i].a1);
      chk($sformatf("R6 vec%0d a2", i),   plane_addr[95:64], VECS[i].a2);
      chk($sformatf("R3 vec%0d buf", i),  {31'd0, buf_idx},  {31'd0, VECS[i].bi});
      chk($sformatf("R9 vec%0d evt", i),  {31'd0, line_evt}, {31'd0, VECS[i].ev});
    end

    // one plane, ping-pong off, wrap off, event every line
    cfg_mode = 2'd0; cfg_pingpong = 1'b0; cfg_wrap_en = 1'b0; cfg_evt_code = 3'd0;
    apply(1'b1, 1'b0, 3'b000);
    chk("R2 single-set buf", {31'd0, buf_idx}, 32'd0);
    chk("R2 single-set a0", plane_addr[31:0], 32'h1000);
    apply(1'b0, 1'b0, 3'b110);
    chk("R4 inactive a1", plane_addr[63:32], 32'h2000);
    chk("R4 inactive a2", plane_addr[95:64], 32'h3000);
    apply(1'b0, 1'b1, 3'b000);
    chk("R5 a0 line", plane_addr[31:0], 32'h1100);
    chk("R9 every line evt", {31'd0, line_evt}, 32'd1);
    chk("R4 inactive a1 line", plane_addr[63:32], 32'h2000);
    apply(1'b1, 1'b0, 3'b000);
    chk("R2 second frame buf", {31'd0, buf_idx}, 32'd0);

    // widest event interval with wrap off
    cfg_evt_code = 3'd7;
    apply(1'b1, 1'b0, 3'b000);
    evt_seen = 0;
    for (int l = 0; l < 127; l++) begin
      apply(1'b0, 1'b1, 3'b000);
      evt_seen += int'(line_evt);
    end
    chk("R9 no early evt", evt_seen, 0);
    apply(1'b0, 1'b1, 3'b000);
    chk("R9 evt at 128", {31'd0, line_evt}, 32'd1);
    apply(1'b0, 1'b1, 3'b000);
    chk("R9 pulse one cycle", {31'd0, line_evt}, 32'd0);
    apply(1'b0, 1'b1, 3'b000);
    chk("R8 no wrap a0", plane_addr[31:0], 32'h9200);

    // two planes, full-rate chroma; mid-frame pitch change ignored
    cfg_mode = 2'd1; cfg_evt_code = 3'd0;
    apply(1'b1, 1'b0, 3'b000);
    cfg_pitch[15:0] = 16'h0040;
    apply(1'b0, 1'b1, 3'b000);
    chk("R10 latched pitch a0", plane_addr[31:0], 32'h1100);
    chk("R6 full chroma a1", plane_addr[63:32], 32'h2080);
    chk("R6 plane2 off a2", plane_addr[95:64], 32'h3000);

    finish_run();
  end
endmodule